// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block connects two parallel buses, A and B, that share one set of data lines per side. Each direction has its own storage register, and each register is loaded from its source bus on its own rising clock. A side can therefore send either the data present at that moment on the far bus or a word captured earlier. Which side is driven, if any, depends on one global disable input and one direction input. The driven bus receives either the live word or the stored word, chosen by a per-direction select.

The pins are modelled as a separate input vector, output vector and output enable for each side. The tri-state driver at the chip boundary combines these three. A build parameter chooses whether the driven side carries the data as it is or its bitwise complement.

The live-or-stored selection is one word-wide choice, applied before the optional inversion. A change of select therefore moves the output directly from the old source to the new one, and no bit mixes the two.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage registers hold zero and both `a_oe` and `b_oe` are low. After release, selecting stored data drives the zero word, or its complement when inverted.
- R2: When `bus_off` is 1, `a_oe` and `b_oe` are both 0, whatever the other inputs are.
- R3: When `bus_off` is 0, `dir_a2b` = 1 drives B only (`b_oe`=1, `a_oe`=0), and `dir_a2b` = 0 drives A only (`a_oe`=1, `b_oe`=0).
- R4: With `sel_a2b_store` = 0 and B driven, `b_out` follows `a_in` combinationally, in the same cycle.
- R5: With `sel_a2b_store` = 1 and B driven, `b_out` shows the word held in the A-to-B register.
- R6: With `sel_b2a_store` = 0 and A driven, `a_out` follows `b_in`. With `sel_b2a_store` = 1, `a_out` shows the word held in the B-to-A register.
- R7: The A-to-B register loads `a_in` on each rising edge of `clk_a2b` and holds its value between edges.
- R8: The B-to-A register loads `b_in` on each rising edge of `clk_b2a` and holds its value between edges.
- R9: Both registers still load while `bus_off` is 1.
- R10: A register loads from its bus input vector even while the block drives that same bus. Its output word has no effect on the capture.
- R11: `a_oe` and `b_oe` are never 1 at the same time.
- R12: With `INVERT` = 1, every driven output word is the bitwise complement of the word that the `INVERT` = 0 build drives for the same inputs.
- R13: When a select changes while the data stays steady, the driven output takes only the old source's value and then the new source's value. It never takes any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of both registers; also masks both enables |
| clk_a2b | input | 1 | Rising edge loads `a_in` into the A-to-B register |
| clk_b2a | input | 1 | Rising edge loads `b_in` into the B-to-A register |
| bus_off | input | 1 | 1 releases both buses; captures continue |
| dir_a2b | input | 1 | 1 drives B from the A side, 0 drives A from the B side |
| sel_a2b_store | input | 1 | 0 sends live A data to B, 1 sends the stored A-to-B word |
| sel_b2a_store | input | 1 | 0 sends live B data to A, 1 sends the stored B-to-A word |
| a_in | input | WIDTH | Data seen on the A lines |
| a_out | output | WIDTH | Data to place on the A lines when `a_oe` is 1 |
| a_oe | output | 1 | Enable of the A-side driver |
| b_in | input | WIDTH | Data seen on the B lines |
| b_out | output | WIDTH | Data to place on the B lines when `b_oe` is 1 |
| b_oe | output | 1 | Enable of the B-side driver |

## Verification
The bench builds two copies side by side, one with `INVERT` = 0 and one with `INVERT` = 1, both at the default width of 8. It feeds them the same stimulus and checks both against one model. Every comparison therefore covers the true and the complemented data paths at once, and any inversion applied to the wrong word, or on the wrong side, shows up as a difference between the two copies.

Each capture clock is a gated copy of the bench clock. This lets loads happen in cycles chosen to fall while the block is disabled or driving the captured bus. It also lets the select toggle under steady data, with a monitor watching every change of the output.

// File: rtl/regbus_xcvr.sv
`timescale 1ns/1ps
module regbus_xcvr #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             rst_n,
  input  logic             clk_a2b,
  input  logic             clk_b2a,
  input  logic             bus_off,
  input  logic             dir_a2b,
  input  logic             sel_a2b_store,
  input  logic             sel_b2a_store,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  logic [WIDTH-1:0] held_ab, held_ba;
  logic [WIDTH-1:0] word_to_b, word_to_a;

  always_ff @(posedge clk_a2b or negedge rst_n)
    if (!rst_n) held_ab <= '0;
    else        held_ab <= a_in;

  always_ff @(posedge clk_b2a or negedge rst_n)
    if (!rst_n) held_ba <= '0;
    else        held_ba <= b_in;

  // one word-wide choice per direction: no bit can mix the two sources
  assign word_to_b = sel_a2b_store ? held_ab : a_in;
  assign word_to_a = sel_b2a_store ? held_ba : b_in;

  generate
    if (INVERT) begin : g_inv
      assign b_out = ~word_to_b;
      assign a_out = ~word_to_a;
    end else begin : g_true
      assign b_out = word_to_b;
      assign a_out = word_to_a;
    end
  endgenerate

  assign b_oe = rst_n & ~bus_off &  dir_a2b;
  assign a_oe = rst_n & ~bus_off & ~dir_a2b;

endmodule

// File: rtl/regbus_xcvr_chk.sv
`timescale 1ns/1ps
module regbus_xcvr_chk #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             rst_n,
  input logic             clk_a2b,
  input logic             clk_b2a,
  input logic             bus_off,
  input logic             sel_a2b_store,
  input logic             sel_b2a_store,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe
);

  function automatic logic [WIDTH-1:0] pol(input logic [WIDTH-1:0] w);
    return INVERT ? ~w : w;
  endfunction

  always_comb begin
    if (rst_n === 1'b0)
      p_reset_quiet_r1: assert (!a_oe && !b_oe);
  end

  p_off_quiet_r2: assert property (@(posedge clk_a2b) disable iff (!rst_n)
    bus_off |-> (!a_oe && !b_oe));

  p_one_side_a_r11: assert property (@(posedge clk_a2b) disable iff (!rst_n)
    !(a_oe && b_oe));

  p_one_side_b_r11: assert property (@(posedge clk_b2a) disable iff (!rst_n)
    !(a_oe && b_oe));

  p_stored_to_b_r5: assert property (@(posedge clk_a2b) disable iff (!rst_n)
    ($past(rst_n) && sel_a2b_store && b_oe) |-> (b_out == pol($past(a_in))));

  p_stored_to_a_r6: assert property (@(posedge clk_b2a) disable iff (!rst_n)
    ($past(rst_n) && sel_b2a_store && a_oe) |-> (a_out == pol($past(b_in))));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
  .rst_n(rst_n), .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .bus_off(bus_off),
  .sel_a2b_store(sel_a2b_store), .sel_b2a_store(sel_b2a_store),
  .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/regbus_xcvr_bench.sv
`timescale 1ns/1ps
module regbus_xcvr_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, cap_a = 1'b0, cap_b = 1'b0;
  logic off = 1'b1, dir = 1'b0, sab = 1'b0, sba = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic clk_a2b, clk_b2a;
  assign clk_a2b = clk & cap_a;
  assign clk_b2a = clk & cap_b;

  logic [7:0] a_out0, b_out0, a_out1, b_out1;
  logic a_oe0, b_oe0, a_oe1, b_oe1;

  regbus_xcvr #(.WIDTH(8), .INVERT(1'b0)) u_regbus_xcvr (
    .rst_n(rst_n), .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .bus_off(off),
    .dir_a2b(dir), .sel_a2b_store(sab), .sel_b2a_store(sba),
    .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0));

  regbus_xcvr #(.WIDTH(8), .INVERT(1'b1)) u_regbus_xcvr_inv (
    .rst_n(rst_n), .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .bus_off(off),
    .dir_a2b(dir), .sel_a2b_store(sab), .sel_b2a_store(sba),
    .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1));

  int checks = 0, fails = 0;
  logic [7:0] m_ab = '0, m_ba = '0;
  logic glitch_watch = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic ea, eb;
    logic [7:0] xb, xa;
    ea = rst_n && !off && !dir;
    eb = rst_n && !off && dir;
    xb = sab ? m_ab : a_in;
    xa = sba ? m_ba : b_in;
    chk(tag, "enables", {14'd0, a_oe0, b_oe0}, {14'd0, ea, eb});
    chk({tag, " R12"}, "enables inv", {14'd0, a_oe1, b_oe1}, {14'd0, ea, eb});
    chk("R11", "both enables", {15'd0, a_oe0 & b_oe0}, 16'd0);
    if (eb) begin
      chk(tag, "b_out", {8'd0, b_out0}, {8'd0, xb});
      chk({tag, " R12"}, "b_out inv", {8'd0, b_out1}, {8'd0, ~xb});
    end
    if (ea) begin
      chk(tag, "a_out", {8'd0, a_out0}, {8'd0, xa});
      chk({tag, " R12"}, "a_out inv", {8'd0, a_out1}, {8'd0, ~xa});
    end
  endtask

  task automatic cyc(input string tag, input logic o, input logic d, input logic s1, input logic s2,
                     input logic ca, input logic cb, input logic [7:0] av, input logic [7:0] bv);
    #1;
    off = o; dir = d; sab = s1; sba = s2; cap_a = ca; cap_b = cb; a_in = av; b_in = bv;
    @(posedge clk);
    if (rst_n) begin
      if (ca) m_ab = av;
      if (cb) m_ba = bv;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  always @(b_out0) begin
    if (glitch_watch && b_oe0) begin
      checks++;
      if (b_out0 !== a_in && b_out0 !== m_ab) begin
        fails++;
        $display("FAIL R13 b_out transition: actual %h expected %h or %h", b_out0, a_in, m_ab);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: captures during reset are ignored, enables held low
    cyc("R1", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF);
    cyc("R1", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF);
    #1 rst_n = 1'b1;
    cyc("R1", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hAA, 8'hBB);
    cyc("R1", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hAA, 8'hBB);
    // R4: live A to B
    cyc("R4", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h00);
    cyc("R4", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h00);
    cyc("R4", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    cyc("R4", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00);
    // R5, R7: load then hold
    cyc("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h00);
    cyc("R7", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h00);
    cyc("R7", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, 8'h00);
    // R6, R8: B to A, stored and live
    cyc("R8", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h96);
    cyc("R8", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h21, 8'h42);
    cyc("R6", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h21, 8'h42);
    cyc("R6", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h21, 8'hE7);
    // R2, R9: released buses still capture
    cyc("R2", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h12, 8'h34);
    cyc("R9", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h11, 8'h22);
    cyc("R9", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h99, 8'h99);
    cyc("R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h99, 8'h99);
    // R10: load B while driving B with a different word
    cyc("R10", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h44, 8'h77);
    cyc("R10", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h44, 8'h00);
    // R3: direction flips
    cyc("R3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5C, 8'hC5);
    cyc("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5C, 8'hC5);
    cyc("R3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5C, 8'hC5);
    // R13: toggle the select under steady data (stored 0x11, live 0xEE)
    cyc("R13", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hEE, 8'h00);
    glitch_watch = 1'b1;
    for (int i = 0; i < 6; i++)
      cyc("R13", 1'b0, 1'b1, i[0] ? 1'b0 : 1'b1, 1'b0, 1'b0, 1'b0, 8'hEE, 8'h00);
    glitch_watch = 1'b0;
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      cyc("R3", r[0] & r[1], r[2], r[3], r[4], r[5], r[6], 8'($urandom), 8'($urandom));
    end
    finish_run();
  end
endmodule